// File: doc/BRIEF.md
# Transmit/Receive Byte FIFO Pair with Thresholds and Flush

This block holds the byte buffering of a serial bus controller: one FIFO carries bytes from the register side toward the bus engine, the other carries bytes back from the bus engine to the register side. The register side writes into the transmit FIFO and reads from the receive FIFO. The bus engine pops from the transmit FIFO and pushes into the receive FIFO. Each FIFO has an occupancy counter, and a programmable 4-bit threshold sets when its level flag fires. Those flags go to an interrupt block outside this one.

Software can empty either FIFO with a flush request. A flush runs for a fixed number of cycles. Its busy bit reads as set until the FIFO is empty again, so software polls it. While a flush runs, traffic into and out of that FIFO is ignored and its level flags stay low. A register-side write into a full transmit FIFO is dropped and raises an overrun event.

Top module: `txrx_byte_fifo`

## Requirements
- R1: Each FIFO returns bytes in the order they were accepted. The usable capacity is 15 bytes in a 16-entry store. A push into a FIFO that already holds 15 bytes is dropped. A pop from an empty FIFO has no effect. The head byte of the transmit FIFO appears on `eng_tx_data`.
- R2: `tx_full` is high while the transmit FIFO holds 15 bytes and no flush is running. A `tx_wr_en` write arriving at a clock edge when the count is 15 and no flush is running is dropped, and `tx_overrun` is high for exactly the following cycle. In every other case `tx_overrun` is low.
- R3: `rx_nearly_full` is high when the receive count is greater than or equal to `rx_thresh` (a value from 0 to 15) and no receive flush is running.
- R4: `rx_full` is high when the receive FIFO holds 15 bytes and no receive flush is running.
- R5: `tx_nearly_empty` is high when the transmit count is less than or equal to `tx_thresh` and no transmit flush is running. It signals room for 15 minus `tx_thresh` more bytes.
- R6: A flush request sampled while that FIFO is idle makes its busy output high for exactly 4 cycles. On the edge where busy falls, the count becomes 0. A request sampled while busy is ignored. The two flushes are independent.
- R7: While a FIFO's busy output is high, pushes, pops and writes to it are ignored, no overrun is raised, and its threshold and full flags are low.
- R8: `rx_rd_data` shows the receive head byte, or 0x00 when the receive FIFO is empty. A read strobe on an empty receive FIFO leaves the count at 0.
- R9: `tx_empty` and `rx_empty` are high exactly when the matching count is 0, including while a flush runs.
- R10: After reset, both counts are 0, both empty flags are high, `tx_overrun`, `tx_full`, `rx_full` and both busy outputs are low, and both level flags follow R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Register-side write strobe into the transmit FIFO |
| tx_wr_data | input | 8 | Byte to write |
| rx_rd_en | input | 1 | Register-side read strobe, pops the receive head |
| rx_rd_data | output | 8 | Receive head byte, 0x00 when empty |
| tx_flush_req | input | 1 | Start a transmit flush |
| rx_flush_req | input | 1 | Start a receive flush |
| tx_flush_busy | output | 1 | Transmit flush in progress |
| rx_flush_busy | output | 1 | Receive flush in progress |
| tx_thresh | input | 4 | Transmit threshold |
| rx_thresh | input | 4 | Receive threshold |
| eng_tx_pop | input | 1 | Bus engine takes the transmit head |
| eng_tx_data | output | 8 | Transmit head byte, 0x00 when empty |
| eng_rx_push | input | 1 | Bus engine pushes a received byte |
| eng_rx_data | input | 8 | Received byte |
| tx_count | output | 5 | Transmit occupancy |
| rx_count | output | 5 | Receive occupancy |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_nearly_empty | output | 1 | Transmit count at or below threshold |
| tx_full | output | 1 | Transmit FIFO at capacity |
| tx_overrun | output | 1 | One-cycle event after a write to a full transmit FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_nearly_full | output | 1 | Receive count at or above threshold |
| rx_full | output | 1 | Receive FIFO at capacity |

## Verification
The bench uses the default parameters: a 16-entry store with 15 usable bytes, 4-bit thresholds and a 4-cycle flush. With these values the usable capacity equals the largest threshold, so both compare boundaries can be reached: threshold 0 and threshold 15 against counts of 0 and 15. The short flush also lets many flushes be started during random traffic, including requests that arrive during a flush and flushes that overlap the other direction's flush.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_RUN  = 1'b1
  } flush_state_e;

  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_DEPTH    = 16;
  localparam int unsigned DEF_THRESH_W = 4;
  localparam int unsigned DEF_FLUSH_CY = 4;

endpackage

// File: rtl/fp_flush_seq.sv
module fp_flush_seq
  import fifo_pair_pkg::*;
#(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic done
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  flush_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      FL_IDLE: begin
        if (req) begin
          state_d = FL_RUN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      FL_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) begin
          state_d = FL_IDLE;
          cnt_d   = '0;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = FL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FL_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q == FL_RUN);

endmodule

// File: rtl/fp_store.sv
module fp_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CAP   = 15,
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   din,
  input  logic            pop,
  input  logic            clear,
  output logic [DW-1:0]   head,
  output logic [CNTW-1:0] count
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0]   PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CAP_C    = CNTW'(CAP);

  logic [DW-1:0]   mem_q [DEPTH];
  logic [PW-1:0]   wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]   rd_ptr_q, rd_ptr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            push_ok, pop_ok;

  assign push_ok = push && (cnt_q < CAP_C);
  assign pop_ok  = pop && (cnt_q != '0);

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clear) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clear) begin
      mem_q[wr_ptr_q] <= din;
    end
  end

  assign head  = (cnt_q == '0) ? '0 : mem_q[rd_ptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/fp_thresh_cmp.sv
module fp_thresh_cmp #(
  parameter int unsigned CNTW     = 5,
  parameter int unsigned THW      = 4,
  parameter bit          AT_LEAST = 1'b1
) (
  input  logic [CNTW-1:0] count,
  input  logic [THW-1:0]  thresh,
  input  logic            hold_off,
  output logic            hit
);

  localparam int unsigned WW = (CNTW > THW) ? CNTW : THW;

  logic [WW-1:0] cnt_w, th_w;
  logic          raw;

  assign cnt_w = WW'(count);
  assign th_w  = WW'(thresh);

  generate
    if (AT_LEAST) begin : g_ge
      assign raw = (cnt_w >= th_w);
    end else begin : g_le
      assign raw = (cnt_w <= th_w);
    end
  endgenerate

  assign hit = raw && !hold_off;

endmodule

// File: rtl/txrx_byte_fifo.sv
module txrx_byte_fifo
  import fifo_pair_pkg::*;
#(
  parameter int unsigned DATA_W       = DEF_DATA_W,
  parameter int unsigned DEPTH        = DEF_DEPTH,
  parameter int unsigned THRESH_W     = DEF_THRESH_W,
  parameter int unsigned FLUSH_CYCLES = DEF_FLUSH_CY,
  parameter int unsigned CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_wr_en,
  input  logic [DATA_W-1:0]   tx_wr_data,
  input  logic                rx_rd_en,
  output logic [DATA_W-1:0]   rx_rd_data,
  input  logic                tx_flush_req,
  input  logic                rx_flush_req,
  output logic                tx_flush_busy,
  output logic                rx_flush_busy,
  input  logic [THRESH_W-1:0] tx_thresh,
  input  logic [THRESH_W-1:0] rx_thresh,
  input  logic                eng_tx_pop,
  output logic [DATA_W-1:0]   eng_tx_data,
  input  logic                eng_rx_push,
  input  logic [DATA_W-1:0]   eng_rx_data,
  output logic [CNT_W-1:0]    tx_count,
  output logic [CNT_W-1:0]    rx_count,
  output logic                tx_empty,
  output logic                tx_nearly_empty,
  output logic                tx_full,
  output logic                tx_overrun,
  output logic                rx_empty,
  output logic                rx_nearly_full,
  output logic                rx_full
);

  localparam int unsigned CAP = DEPTH - 1;
  localparam logic [CNT_W-1:0] CAP_C = CNT_W'(CAP);

  logic tx_busy, tx_done, rx_busy, rx_done;
  logic ovr_q, ovr_d;

  fp_flush_seq #(.CYCLES(FLUSH_CYCLES)) u_tx_flush (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (tx_flush_req),
    .busy  (tx_busy),
    .done  (tx_done)
  );

  fp_flush_seq #(.CYCLES(FLUSH_CYCLES)) u_rx_flush (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (rx_flush_req),
    .busy  (rx_busy),
    .done  (rx_done)
  );

  fp_store #(.DW(DATA_W), .DEPTH(DEPTH), .CAP(CAP), .CNTW(CNT_W)) u_tx_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_wr_en && !tx_busy),
    .din   (tx_wr_data),
    .pop   (eng_tx_pop && !tx_busy),
    .clear (tx_done),
    .head  (eng_tx_data),
    .count (tx_count)
  );

  fp_store #(.DW(DATA_W), .DEPTH(DEPTH), .CAP(CAP), .CNTW(CNT_W)) u_rx_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (eng_rx_push && !rx_busy),
    .din   (eng_rx_data),
    .pop   (rx_rd_en && !rx_busy),
    .clear (rx_done),
    .head  (rx_rd_data),
    .count (rx_count)
  );

  fp_thresh_cmp #(.CNTW(CNT_W), .THW(THRESH_W), .AT_LEAST(1'b0)) u_tx_cmp (
    .count    (tx_count),
    .thresh   (tx_thresh),
    .hold_off (tx_busy),
    .hit      (tx_nearly_empty)
  );

  fp_thresh_cmp #(.CNTW(CNT_W), .THW(THRESH_W), .AT_LEAST(1'b1)) u_rx_cmp (
    .count    (rx_count),
    .thresh   (rx_thresh),
    .hold_off (rx_busy),
    .hit      (rx_nearly_full)
  );

  assign ovr_d = tx_wr_en && !tx_busy && (tx_count == CAP_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
    end
  end

  assign tx_overrun    = ovr_q;
  assign tx_flush_busy = tx_busy;
  assign rx_flush_busy = rx_busy;
  assign tx_empty      = (tx_count == '0);
  assign rx_empty      = (rx_count == '0);
  assign tx_full       = (tx_count == CAP_C) && !tx_busy;
  assign rx_full       = (rx_count == CAP_C) && !rx_busy;

endmodule

// File: rtl/txrx_fifo_checker.sv
module txrx_fifo_checker #(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CAP    = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_wr_en,
  input logic              tx_overrun,
  input logic              tx_full,
  input logic              tx_nearly_empty,
  input logic              tx_flush_busy,
  input logic              rx_flush_busy,
  input logic              rx_full,
  input logic              rx_nearly_full,
  input logic              rx_empty,
  input logic [DATA_W-1:0] rx_rd_data,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count
);

  // R1: occupancy never exceeds the usable capacity
  a_r1_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CNT_W'(CAP));
  a_r1_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(CAP));

  // R2: overrun only follows a write seen at full count
  a_r2_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |-> ($past(tx_wr_en) && ($past(tx_count) == CNT_W'(CAP)) && !$past(tx_flush_busy)));

  // R4: full flag implies full count
  a_r4_rx_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> (rx_count == CNT_W'(CAP)));

  // R6: a flush leaves its FIFO empty
  a_r6_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_flush_busy) |-> (tx_count == '0));
  a_r6_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_flush_busy) |-> (rx_count == '0));

  // R7: level flags held low during a flush
  a_r7_tx_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_busy |-> (!tx_full && !tx_nearly_empty));
  a_r7_rx_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_busy |-> (!rx_full && !rx_nearly_full));

  // R8: empty receive FIFO reads as zero
  a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (rx_rd_data == '0));

endmodule

bind txrx_byte_fifo txrx_fifo_checker #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .CAP    (DEPTH - 1)
) u_txrx_fifo_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .tx_wr_en        (tx_wr_en),
  .tx_overrun      (tx_overrun),
  .tx_full         (tx_full),
  .tx_nearly_empty (tx_nearly_empty),
  .tx_flush_busy   (tx_flush_busy),
  .rx_flush_busy   (rx_flush_busy),
  .rx_full         (rx_full),
  .rx_nearly_full  (rx_nearly_full),
  .rx_empty        (rx_empty),
  .rx_rd_data      (rx_rd_data),
  .tx_count        (tx_count),
  .rx_count        (rx_count)
);

// File: tb/test_txrx_byte_fifo.sv
`timescale 1ns/1ps
module test_txrx_byte_fifo;

  localparam int CAPN = 15;
  localparam int FLN  = 4;

  logic       clk;
  logic       rst_n;
  logic       tx_wr_en, rx_rd_en, tx_flush_req, rx_flush_req;
  logic       eng_tx_pop, eng_rx_push;
  logic [7:0] tx_wr_data, eng_rx_data;
  logic [3:0] tx_thresh, rx_thresh;
  logic [7:0] rx_rd_data, eng_tx_data;
  logic       tx_flush_busy, rx_flush_busy;
  logic [4:0] tx_count, rx_count;
  logic       tx_empty, tx_nearly_empty, tx_full, tx_overrun;
  logic       rx_empty, rx_nearly_full, rx_full;

  int checks = 0;
  int errors = 0;

  byte unsigned tq[$];
  byte unsigned rq[$];
  int  tbusy = 0;
  int  rbusy = 0;
  bit  m_ovr = 0;

  txrx_byte_fifo i_txrx_byte_fifo (
    .clk(clk), .rst_n(rst_n),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
    .tx_flush_req(tx_flush_req), .rx_flush_req(rx_flush_req),
    .tx_flush_busy(tx_flush_busy), .rx_flush_busy(rx_flush_busy),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_empty(tx_empty), .tx_nearly_empty(tx_nearly_empty),
    .tx_full(tx_full), .tx_overrun(tx_overrun),
    .rx_empty(rx_empty), .rx_nearly_full(rx_nearly_full), .rx_full(rx_full)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit tb, rb;
    tb = (tbusy > 0);
    rb = (rbusy > 0);
    chk("R1 tx_count", tx_count, tq.size());
    chk("R1 rx_count", rx_count, rq.size());
    chk("R1 eng_tx_data", eng_tx_data, (tq.size() > 0) ? tq[0] : 0);
    chk("R8 rx_rd_data", rx_rd_data, (rq.size() > 0) ? rq[0] : 0);
    chk("R2 tx_full", tx_full, (!tb && tq.size() == CAPN));
    chk("R2 tx_overrun", tx_overrun, m_ovr);
    chk("R3 rx_nearly_full", rx_nearly_full, (!rb && rq.size() >= rx_thresh));
    chk("R4 rx_full", rx_full, (!rb && rq.size() == CAPN));
    chk("R5 tx_nearly_empty", tx_nearly_empty, (!tb && tq.size() <= tx_thresh));
    chk("R6 tx_flush_busy", tx_flush_busy, tb);
    chk("R6 rx_flush_busy", rx_flush_busy, rb);
    chk("R9 tx_empty", tx_empty, (tq.size() == 0));
    chk("R9 rx_empty", rx_empty, (rq.size() == 0));
  endtask

  // Apply inputs, clock once, advance the model, compare away from the edge
  task automatic step(input bit w, input byte unsigned wd, input bit rd,
                      input bit pop, input bit push, input byte unsigned pd,
                      input bit ft, input bit fr);
    tx_wr_en = w; tx_wr_data = wd; rx_rd_en = rd; eng_tx_pop = pop;
    eng_rx_push = push; eng_rx_data = pd; tx_flush_req = ft; rx_flush_req = fr;
    @(posedge clk);
    m_ovr = (tbusy == 0) && w && (tq.size() == CAPN);
    if (tbusy > 0) begin
      tbusy--;
      if (tbusy == 0) tq.delete();
    end else begin
      int sz;
      sz = tq.size();
      if (pop && sz > 0) void'(tq.pop_front());
      if (w && sz < CAPN) tq.push_back(wd);
      if (ft) tbusy = FLN;
    end
    if (rbusy > 0) begin
      rbusy--;
      if (rbusy == 0) rq.delete();
    end else begin
      int sz;
      sz = rq.size();
      if (rd && sz > 0) void'(rq.pop_front());
      if (push && sz < CAPN) rq.push_back(pd);
      if (fr) rbusy = FLN;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_wr_en = 0; tx_wr_data = 0; rx_rd_en = 0; eng_tx_pop = 0;
    eng_rx_push = 0; eng_rx_data = 0; tx_flush_req = 0; rx_flush_req = 0;
    tx_thresh = 4'd2; rx_thresh = 4'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 tx_count", tx_count, 0);
    chk("R10 rx_empty", rx_empty, 1);
    chk("R10 tx_overrun", tx_overrun, 0);
    compare_all();

    // R8: read from empty receive FIFO
    step(0, 0, 1, 1, 0, 0, 0, 0);

    // R1/R2: fill transmit to capacity, then overrun twice
    for (int i = 0; i < 17; i++) step(1, byte'(8'h10 + i), 0, 0, 0, 0, 0, 0);
    idle(1);
    // write plus pop at full: write dropped, overrun raised
    step(1, 8'hEE, 0, 1, 0, 0, 0, 0);
    // drain while changing thresholds (R5 boundaries 0 and 15)
    tx_thresh = 4'd15;
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
    tx_thresh = 4'd0;
    idle(1);

    // R3/R4: fill receive with thresholds 0 and 15
    rx_thresh = 4'd15;
    for (int i = 0; i < 17; i++) step(0, 0, 0, 0, 1, byte'(8'hA0 + i), 0, 0);
    rx_thresh = 4'd0;
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, 0, 0, 0);

    // R6/R7: flush both with traffic during flush, and a request while busy
    step(1, 8'h55, 0, 0, 1, 8'h66, 1, 1);
    for (int i = 0; i < 6; i++) step(1, byte'(i), 1, 1, 1, byte'(i), (i == 1), (i == 2));
    idle(2);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      bit ft, fr;
      if (i % 500 == 0) begin
        tx_thresh = 4'($urandom_range(0, 15));
        rx_thresh = 4'($urandom_range(0, 15));
      end
      ft = ($urandom_range(0, 99) < 2);
      fr = ($urandom_range(0, 99) < 2);
      step(($urandom_range(0, 99) < ((i / 250) % 2 ? 70 : 35)), 8'($urandom),
           ($urandom_range(0, 99) < ((i / 250) % 2 ? 30 : 65)),
           ($urandom_range(0, 99) < ((i / 250) % 2 ? 30 : 65)),
           ($urandom_range(0, 99) < ((i / 250) % 2 ? 70 : 35)), 8'($urandom),
           ft, fr);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule